// File: doc/BRIEF.md
# One-Shot Pulse Generator

This block is a clocked digital monostable. Its output rests low. A rising edge on the trigger input, sampled on the clock, drives the output high for a programmable number of clock cycles. The width comes from an input bus and is captured at the moment a pulse starts or restarts.

A mode input chooses how a trigger that arrives while a pulse is running is treated. In one mode such a trigger is dropped and the pulse keeps its original end time. In the other mode the trigger reloads the full width, so the pulse stretches to a width's worth of cycles after the most recent trigger. A trigger that lands in the final high cycle of a pulse is accepted in either mode, so back-to-back pulses join without a low gap.

Typical uses are stretching a short event into a visible strobe and building a "still active" window that stays open while events keep arriving.

Top module: `mono_pulse`

## Requirements
- R1: Synchronous reset (rst_i=1 at a rising clock edge) forces pulse_o to 0 from that edge on, including in the middle of a pulse. It also clears the remaining count and the stored trigger level, so no pulse is in progress after reset.
- R2: If no trigger is accepted, pulse_o stays at 0.
- R3: A trigger is a clock edge at which trig_i is 1 after it was 0 at the previous edge. A trig_i held at 1 produces no further triggers, in either mode.
- R4: A trigger accepted at clock edge k with width W = tp_i (W > 0, tp_i sampled at edge k) makes pulse_o 1 for exactly W cycles, starting just after edge k. pulse_o then returns to 0.
- R5: A trigger accepted while idle with tp_i = 0 produces no pulse: pulse_o stays 0.
- R6: With retrig_i = 0 (ignore mode), a trigger that arrives while pulse_o is 1 and the pulse is not in its final cycle has no effect, and the pulse ends at its original time.
- R7: With retrig_i = 1 (restart mode), a trigger while pulse_o is 1 reloads the width from tp_i at that edge. pulse_o then stays 1 for exactly that many cycles after the trigger edge.
- R8: In either mode, a trigger at the edge that ends the final high cycle of a pulse starts a new pulse with no low cycle between the two pulses.
- R9: In either mode, a trigger after a pulse has ended starts a fresh pulse of the current tp_i width.
- R10: Changes on tp_i while a pulse runs have no effect on that pulse's end time. tp_i is used only at an accepted trigger.
- R11: In restart mode, a trigger during a pulse with tp_i = 0 ends the pulse: pulse_o is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger level; its rising edge, sampled on the clock, is the trigger event |
| tp_i | input | CNT_W | Pulse width in clock cycles, captured at an accepted trigger |
| retrig_i | input | 1 | 0 = ignore triggers during a pulse, 1 = restart the width on each trigger |
| pulse_o | output | 1 | One-shot output, high while a pulse runs |

## Verification
The delicate coincidence is a trigger edge that falls on the same clock edge at which the running count expires. The design must then accept the trigger and keep the output high, rather than letting the expiry win and leaving a one-cycle dip. The bench provokes this by spacing two edges exactly the pulse width apart, in both modes. It judges the result by comparing pulse_o on every cycle against an expected stream computed from the requirements. A second overlap, a restart edge that arrives while the count is decrementing, is exercised in restart mode with both a nonzero width and a zero width.

// File: rtl/mono_pulse_pkg.sv
package mono_pulse_pkg;

   // Policy for triggers that land while a pulse is running
   typedef enum logic {
      TRIG_IGNORE_BUSY = 1'b0,
      TRIG_RESTART     = 1'b1
   } retrig_mode_e;

   // Status decoded from the remaining-cycle counter
   typedef struct packed {
      logic busy;   // count is nonzero: output high
      logic last;   // count is one: final high cycle
   } ctr_status_t;

   localparam int MIN_CNT_W = 1;
   localparam int MAX_CNT_W = 32;

endpackage

// File: rtl/mono_rise_detect.sv
module mono_rise_detect (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lvl_i,
   output logic rise_o
);

   logic lvl_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lvl_q <= 1'b0;
      end else begin
         lvl_q <= lvl_i;
      end
   end

   assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/mono_accept_policy.sv
module mono_accept_policy
   import mono_pulse_pkg::*;
(
   input  logic         rise_i,
   input  retrig_mode_e mode_i,
   input  ctr_status_t  status_i,
   output logic         load_o
);

   always_comb begin
      unique case (mode_i)
         TRIG_RESTART:     load_o = rise_i;
         TRIG_IGNORE_BUSY: load_o = rise_i & (~status_i.busy | status_i.last);
         default:          load_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/mono_interval_ctr.sv
module mono_interval_ctr
   import mono_pulse_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] width_i,
   output logic [CNT_W-1:0] count_o,
   output ctr_status_t      status_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= CNT_ZERO;
      end else if (load_i) begin
         cnt_q <= width_i;
      end else if (cnt_q != CNT_ZERO) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign count_o       = cnt_q;
   assign status_o.busy = (cnt_q != CNT_ZERO);
   assign status_o.last = (cnt_q == CNT_ONE);

endmodule

// File: rtl/mono_pulse.sv
module mono_pulse
   import mono_pulse_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] tp_i,
   input  logic             retrig_i,
   output logic             pulse_o
);

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("mono_pulse: CNT_W must lie within the supported range");
      end
   endgenerate

   logic             trig_rise;
   logic             load;
   logic [CNT_W-1:0] cnt_q;
   ctr_status_t      status;
   retrig_mode_e     mode;

   assign mode = retrig_mode_e'(retrig_i);

   mono_rise_detect i_rise (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (trig_i),
      .rise_o (trig_rise)
   );

   mono_accept_policy i_policy (
      .rise_i   (trig_rise),
      .mode_i   (mode),
      .status_i (status),
      .load_o   (load)
   );

   mono_interval_ctr #(
      .CNT_W (CNT_W)
   ) i_ctr (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (load),
      .width_i  (tp_i),
      .count_o  (cnt_q),
      .status_o (status)
   );

   assign pulse_o = status.busy;

endmodule

// File: rtl/mono_pulse_chk.sv
module mono_pulse_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             trig_i,
   input logic [CNT_W-1:0] tp_i,
   input logic             retrig_i,
   input logic             pulse_o,
   input logic [CNT_W-1:0] cnt_q
);

   logic seen_lvl;
   logic edge_ev;

   always_ff @(posedge clk_i) begin
      if (rst_i) seen_lvl <= 1'b0;
      else       seen_lvl <= trig_i;
   end

   assign edge_ev = trig_i && !seen_lvl;

   assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> !pulse_o);

   assert_stay_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!edge_ev && !pulse_o) |=> !pulse_o);

   assert_countdown_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!edge_ev && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   assert_zero_width_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (edge_ev && !pulse_o && tp_i == '0) |=> !pulse_o);

   assert_ignore_busy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!retrig_i && edge_ev && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   assert_restart_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (retrig_i && edge_ev) |=> cnt_q == $past(tp_i));

   assert_final_cycle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (edge_ev && cnt_q == CNT_W'(1) && tp_i != '0) |=> pulse_o);

   assert_fresh_start_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (edge_ev && cnt_q == '0) |=> cnt_q == $past(tp_i));

endmodule

bind mono_pulse mono_pulse_chk #(.CNT_W(CNT_W)) i_mono_pulse_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .trig_i   (trig_i),
   .tp_i     (tp_i),
   .retrig_i (retrig_i),
   .pulse_o  (pulse_o),
   .cnt_q    (cnt_q)
);

// File: tb/test_mono_pulse.sv
`timescale 1ns/1ps
module test_mono_pulse;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         trig = 1'b0;
   logic         mode = 1'b0;
   logic [W-1:0] tp = '0;
   logic         pulse;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   int m_rem  = 0;
   bit m_prev = 1'b0;

   always #10 clk = ~clk;

   mono_pulse #(.CNT_W(W)) i_mono_pulse (
      .clk_i    (clk),
      .rst_i    (rst),
      .trig_i   (trig),
      .tp_i     (tp),
      .retrig_i (mode),
      .pulse_o  (pulse)
   );

   // Driver: applies one cycle of stimulus and queues the expected output
   task automatic cyc(input bit r, input bit t, input int w, input bit m, input string tag);
      bit ev;
      @(negedge clk);
      rst  = r;
      trig = t;
      tp   = W'(w);
      mode = m;
      if (r) begin
         m_rem  = 0;
         m_prev = 1'b0;
      end else begin
         ev     = t && !m_prev;
         m_prev = t;
         if (ev && (m_rem <= 1 || m)) m_rem = w;
         else if (m_rem > 0)          m_rem = m_rem - 1;
      end
      exp_q.push_back(m_rem != 0);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares each cycle's output with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() != 0) begin
            bit    e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_run++;
            if (pulse !== e) begin
               n_fail++;
               $display("FAIL %s: pulse_o actual %b expected %b at %0t", tg, pulse, e, $time);
            end
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual still running, expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc(1, 1, 5, 0, "R1 reset with trigger high");
      repeat (4) cyc(0, 0, 5, 0, "R2 idle stays low");

      cyc(0, 1, 5, 0, "R3 rising edge");
      repeat (8) cyc(0, 1, 5, 0, "R4 width with held level");
      repeat (2) cyc(0, 0, 5, 0, "R2 idle");

      cyc(0, 1, 0, 0, "R5 zero width");
      repeat (3) cyc(0, 0, 0, 0, "R5 no pulse");

      cyc(0, 1, 6, 0, "R6 start");
      cyc(0, 0, 6, 0, "R6 running");
      cyc(0, 1, 6, 0, "R6 ignored trigger");
      repeat (6) cyc(0, 0, 6, 0, "R6 original end");

      cyc(0, 1, 4, 0, "R10 start");
      repeat (6) cyc(0, 0, 9, 0, "R10 width change ignored");

      cyc(0, 1, 4, 1, "R7 start");
      repeat (2) cyc(0, 0, 4, 1, "R7 running");
      cyc(0, 1, 4, 1, "R7 restart");
      repeat (6) cyc(0, 0, 4, 1, "R7 extended");

      for (int m = 0; m < 2; m++) begin
         cyc(0, 1, 3, bit'(m), "R8 start");
         repeat (2) cyc(0, 0, 3, bit'(m), "R8 running");
         cyc(0, 1, 3, bit'(m), "R8 final-cycle trigger");
         repeat (5) cyc(0, 0, 3, bit'(m), "R8 no gap");
         cyc(0, 1, 2, bit'(m), "R9 fresh start");
         repeat (4) cyc(0, 0, 2, bit'(m), "R9 fresh pulse");
      end

      cyc(0, 1, 3, 1, "R3 held in restart mode");
      repeat (6) cyc(0, 1, 3, 1, "R3 held level no retrigger");
      cyc(0, 0, 3, 1, "R3 release");

      cyc(0, 1, 5, 1, "R11 start");
      cyc(0, 0, 5, 1, "R11 running");
      cyc(0, 1, 0, 1, "R11 zero-width restart");
      repeat (3) cyc(0, 0, 0, 1, "R11 pulse ended");

      cyc(0, 1, 7, 0, "R1 pulse before reset");
      cyc(0, 0, 7, 0, "R1 pulse running");
      cyc(1, 0, 7, 0, "R1 mid-pulse reset");
      repeat (3) cyc(0, 0, 7, 0, "R1 low after reset");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule